// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block is a small data cache between a processor-side request port and a word-wide memory port. Each request address is split into a tag, a set index and a byte offset. The stored tags of every way in the selected set are compared with the request tag at the same time. A hit completes from the local arrays without touching memory.

On a miss the controller chooses a victim way. An empty way is always taken first. When the set is full, a per-set round-robin pointer chooses the way. A victim holding modified data is written back to its own block address, one word per memory handshake. The missing block is then fetched word by word and the lookup is repeated, so the access completes as a hit. Writes are write-back with write-allocate, and 4-bit byte strobes select which bytes of the addressed word change.

The requester raises `cpu_req` with its command and holds it until `cpu_ready` pulses. With the default parameters the cache has 4 sets of 2 ways, lines of 4 words of 32 bits, and a 12-bit byte address.

Top module: `cache_wb_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, and `cpu_ready` and `mem_req` are low. The first access to any block after reset misses, with no write-back.
- R2: Address bits [1:0] select the byte, bits [3:2] the word, bits [5:4] the set and bits [11:6] form the tag. A read returns the current 32-bit word at `cpu_addr[11:2]`. A refill fetches words 0 to 3 of the block in ascending order.
- R3: An access to a resident block raises `cpu_ready` exactly 2 clock edges after the edge that samples `cpu_req`, with no memory traffic.
- R4: Blocks with the same set index and different tags stay resident at the same time, up to the number of ways, and each one hits.
- R5: On a miss an invalid way of the set is filled, lowest first. If every way is valid, the per-set round-robin pointer chooses the way and then advances. The pointer starts at way 0 after reset.
- R6: A write hit changes only the cache and marks the line dirty. No memory write happens during that access.
- R7: A miss whose victim is dirty first writes the victim's 4 words to the victim's own block address. The latency is then 3 + 2×4 = 11 edges, and memory afterwards holds the victim's latest data.
- R8: A write miss fetches the block and then merges the write, so that a later read of the word returns the merged value.
- R9: On a write, byte lane b (bits 8b+7 to 8b) changes only when `cpu_be[b]` is 1. The other bytes keep their values.
- R10: `cpu_ready` is high for exactly one cycle per access, and `cpu_rdata` is valid while it is high.
- R11: A miss whose victim is clean or invalid causes no memory writes, and its latency is 3 + 4 = 7 edges with a zero-wait memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | WORD_W | Write data |
| cpu_be | input | WORD_W/8 | Byte strobes for writes |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = refill word |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | WORD_W | Write-back data |
| mem_ready | input | 1 | Memory accepts or returns the word this cycle |
| mem_rdata | input | WORD_W | Refill data |

## Verification
A corrupted tag, valid bit or dirty bit does not stay hidden. At the very next access to that set it shows up at the ports as a hit or miss latency different from 2, 7 or 11 edges, or as a write-back burst that should not happen or that is missing. A fault in the data array or in the byte-lane merge shows up as a wrong `cpu_rdata` on the next read of that word. A victim written to the wrong address, or with stale data, shows up as a mismatch in the backing memory as soon as the eviction completes. A bad round-robin pointer or a bad empty-way choice changes which later access misses, usually within a few accesses to the same set.

// File: rtl/cache_wb_pkg.sv
package cache_wb_pkg;
   typedef enum logic [2:0] {
      CS_IDLE,
      CS_LOOKUP,
      CS_WBACK,
      CS_REFILL,
      CS_RESP
   } cstate_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int SETS  = 4,
   parameter int WAYS  = 2,
   parameter int TAG_W = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [$clog2(SETS)-1:0]          idx,
   input  logic [TAG_W-1:0]                 cmp_tag,
   input  logic                             fill_en,
   input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] fill_way,
   input  logic [TAG_W-1:0]                 fill_tag,
   input  logic                             mark_en,
   input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] mark_way,
   output logic [WAYS-1:0]                  way_hit,
   output logic [WAYS-1:0]                  way_valid,
   output logic [WAYS-1:0]                  way_dirty,
   output logic [WAYS-1:0][TAG_W-1:0]       way_tag
);
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  vld_q;
      logic [SETS-1:0]  drt_q;
      logic             fill_me;
      logic             mark_me;

      assign fill_me = fill_en && (fill_way == WAY_W'(w));
      assign mark_me = mark_en && (mark_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
            drt_q <= '0;
         end else if (fill_me) begin
            vld_q[idx] <= 1'b1;
            drt_q[idx] <= 1'b0;
         end else if (mark_me) begin
            drt_q[idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_me) tag_q[idx] <= fill_tag;
      end

      assign way_tag[w]   = tag_q[idx];
      assign way_valid[w] = vld_q[idx];
      assign way_dirty[w] = drt_q[idx];
      assign way_hit[w]   = vld_q[idx] && (tag_q[idx] == cmp_tag);
   end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int SETS       = 4,
   parameter int WAYS       = 2,
   parameter int LINE_WORDS = 4,
   parameter int WORD_W     = 32
) (
   input  logic                                  clk,
   input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0]  rd_way,
   input  logic [$clog2(SETS)-1:0]               rd_idx,
   input  logic [$clog2(LINE_WORDS)-1:0]         rd_word,
   output logic [WORD_W-1:0]                     rd_data,
   input  logic                                  wr_en,
   input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0]  wr_way,
   input  logic [$clog2(SETS)-1:0]               wr_idx,
   input  logic [$clog2(LINE_WORDS)-1:0]         wr_word,
   input  logic [WORD_W-1:0]                     wr_data,
   input  logic [WORD_W/8-1:0]                   wr_be
);
   localparam int DEPTH = WAYS * SETS * LINE_WORDS;
   localparam int A_W   = $clog2(DEPTH);
   localparam int LANES = WORD_W / 8;

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [A_W-1:0]    rd_a;
   logic [A_W-1:0]    wr_a;

   assign rd_a = A_W'((int'(rd_way) * SETS + int'(rd_idx)) * LINE_WORDS + int'(rd_word));
   assign wr_a = A_W'((int'(wr_way) * SETS + int'(wr_idx)) * LINE_WORDS + int'(wr_word));

   assign rd_data = mem_q[rd_a];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < LANES; b++) begin
            if (wr_be[b]) mem_q[wr_a][b*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
   parameter int SETS = 4,
   parameter int WAYS = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [$clog2(SETS)-1:0]               idx,
   input  logic [WAYS-1:0]                       way_valid,
   input  logic                                  adv,
   output logic [((WAYS>1)?$clog2(WAYS):1)-1:0]  victim
);
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (WAYS == 1) begin : g_direct
      logic unused_inputs;
      assign unused_inputs = clk ^ rst_n ^ adv ^ (^idx) ^ (^way_valid);
      assign victim = '0;
   end else begin : g_assoc
      logic [WAY_W-1:0] rr_q [SETS];
      logic             all_valid;

      assign all_valid = &way_valid;

      always_comb begin
         victim = rr_q[idx];
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) victim = WAY_W'(w);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
         end else if (adv && all_valid) begin
            rr_q[idx] <= (rr_q[idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx] + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cache_wb_ctrl.sv
module cache_wb_ctrl
   import cache_wb_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 4,
   parameter int WAYS       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [WORD_W-1:0]   cpu_wdata,
   input  logic [WORD_W/8-1:0] cpu_be,
   output logic                cpu_ready,
   output logic [WORD_W-1:0]   cpu_rdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   input  logic                mem_ready,
   input  logic [WORD_W-1:0]   mem_rdata
);
   localparam int LANES  = WORD_W / 8;
   localparam int BOFF_W = $clog2(LANES);
   localparam int WOFF_W = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (WORD_W % 8 != 0 || WORD_W < 16)
      begin : g_bad_word  $error("WORD_W must be a multiple of 8, at least 16"); end
   if (LINE_WORDS < 2 || (1 << WOFF_W) != LINE_WORDS)
      begin : g_bad_line  $error("LINE_WORDS must be a power of two, at least 2"); end
   if (SETS < 2 || (1 << IDX_W) != SETS)
      begin : g_bad_sets  $error("SETS must be a power of two, at least 2"); end
   if (WAYS < 1)
      begin : g_bad_ways  $error("WAYS must be at least 1"); end
   if (TAG_W < 1)
      begin : g_bad_addr  $error("ADDR_W too small for the geometry"); end

   cstate_e                  state_q;
   logic [ADDR_W-1:BOFF_W]   addr_q;
   logic                     we_q;
   logic [WORD_W-1:0]        wdata_q;
   logic [LANES-1:0]         be_q;
   logic [WAY_W-1:0]         vic_q;
   logic [WOFF_W-1:0]        cnt_q;
   logic [WORD_W-1:0]        rdata_q;

   logic [TAG_W-1:0]         r_tag;
   logic [IDX_W-1:0]         r_idx;
   logic [WOFF_W-1:0]        r_word;
   logic                     unused_byte_off;

   logic [WAYS-1:0]          way_hit;
   logic [WAYS-1:0]          way_valid;
   logic [WAYS-1:0]          way_dirty;
   logic [WAYS-1:0][TAG_W-1:0] way_tag;
   logic [WAY_W-1:0]         hit_way;
   logic [WAY_W-1:0]         victim;
   logic                     any_hit;
   logic                     lkp_hit;
   logic                     lkp_miss;
   logic                     last_word;
   logic                     fill_done;

   logic [WAY_W-1:0]         rd_way;
   logic [WOFF_W-1:0]        rd_word;
   logic [WORD_W-1:0]        rd_data;
   logic                     dw_en;
   logic [WAY_W-1:0]         dw_way;
   logic [WOFF_W-1:0]        dw_word;
   logic [WORD_W-1:0]        dw_data;
   logic [LANES-1:0]         dw_be;

   assign unused_byte_off = ^cpu_addr[BOFF_W-1:0];

   assign r_tag  = addr_q[ADDR_W-1 -: TAG_W];
   assign r_idx  = addr_q[BOFF_W+WOFF_W +: IDX_W];
   assign r_word = addr_q[BOFF_W +: WOFF_W];

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_hit[w]) hit_way = hit_way | WAY_W'(w);
      end
   end

   assign any_hit   = |way_hit;
   assign lkp_hit   = (state_q == CS_LOOKUP) && any_hit;
   assign lkp_miss  = (state_q == CS_LOOKUP) && !any_hit;
   assign last_word = (cnt_q == WOFF_W'(LINE_WORDS - 1));
   assign fill_done = (state_q == CS_REFILL) && mem_ready && last_word;

   cache_tag_store #(
      .SETS (SETS),
      .WAYS (WAYS),
      .TAG_W(TAG_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (r_idx),
      .cmp_tag  (r_tag),
      .fill_en  (fill_done),
      .fill_way (vic_q),
      .fill_tag (r_tag),
      .mark_en  (lkp_hit && we_q),
      .mark_way (hit_way),
      .way_hit  (way_hit),
      .way_valid(way_valid),
      .way_dirty(way_dirty),
      .way_tag  (way_tag)
   );

   cache_victim_pick #(
      .SETS(SETS),
      .WAYS(WAYS)
   ) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (r_idx),
      .way_valid(way_valid),
      .adv      (lkp_miss),
      .victim   (victim)
   );

   assign rd_way  = (state_q == CS_LOOKUP) ? hit_way : vic_q;
   assign rd_word = (state_q == CS_WBACK) ? cnt_q : r_word;

   always_comb begin
      if (state_q == CS_REFILL) begin
         dw_en   = mem_ready;
         dw_way  = vic_q;
         dw_word = cnt_q;
         dw_data = mem_rdata;
         dw_be   = '1;
      end else begin
         dw_en   = lkp_hit && we_q;
         dw_way  = hit_way;
         dw_word = r_word;
         dw_data = wdata_q;
         dw_be   = be_q;
      end
   end

   cache_data_store #(
      .SETS      (SETS),
      .WAYS      (WAYS),
      .LINE_WORDS(LINE_WORDS),
      .WORD_W    (WORD_W)
   ) u_data (
      .clk     (clk),
      .rd_way  (rd_way),
      .rd_idx  (r_idx),
      .rd_word (rd_word),
      .rd_data (rd_data),
      .wr_en   (dw_en),
      .wr_way  (dw_way),
      .wr_idx  (r_idx),
      .wr_word (dw_word),
      .wr_data (dw_data),
      .wr_be   (dw_be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_IDLE;
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         be_q    <= '0;
         vic_q   <= '0;
         cnt_q   <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state_q)
            CS_IDLE: begin
               if (cpu_req) begin
                  addr_q  <= cpu_addr[ADDR_W-1:BOFF_W];
                  we_q    <= cpu_we;
                  wdata_q <= cpu_wdata;
                  be_q    <= cpu_be;
                  state_q <= CS_LOOKUP;
               end
            end
            CS_LOOKUP: begin
               if (any_hit) begin
                  rdata_q <= rd_data;
                  state_q <= CS_RESP;
               end else begin
                  vic_q   <= victim;
                  cnt_q   <= '0;
                  state_q <= (way_valid[victim] && way_dirty[victim]) ? CS_WBACK : CS_REFILL;
               end
            end
            CS_WBACK: begin
               if (mem_ready) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (last_word) state_q <= CS_REFILL;
               end
            end
            CS_REFILL: begin
               if (mem_ready) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (last_word) state_q <= CS_LOOKUP;
               end
            end
            CS_RESP: state_q <= CS_IDLE;
            default: state_q <= CS_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr = '0;
      if (state_q == CS_WBACK)
         mem_addr = {way_tag[vic_q], r_idx, cnt_q, BOFF_W'(0)};
      else if (state_q == CS_REFILL)
         mem_addr = {r_tag, r_idx, cnt_q, BOFF_W'(0)};
   end

   assign mem_req   = (state_q == CS_WBACK) || (state_q == CS_REFILL);
   assign mem_we    = (state_q == CS_WBACK);
   assign mem_wdata = rd_data;
   assign cpu_ready = (state_q == CS_RESP);
   assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cache_wb_chk.sv
module cache_wb_chk #(
   parameter int ADDR_W = 12,
   parameter int WAYS   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WAYS-1:0]   way_hit,
   input logic              lkp_hit
);
   // R3
   hit_responds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_hit |=> cpu_ready);

   // R4
   single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_hit));

   // R10
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   // R2
   mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   // R7
   wback_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> mem_req);

   // R10
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);
endmodule

bind cache_wb_ctrl cache_wb_chk #(
   .ADDR_W(ADDR_W),
   .WAYS  (WAYS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_ready(cpu_ready),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_ready(mem_ready),
   .mem_addr (mem_addr),
   .way_hit  (way_hit),
   .lkp_hit  (lkp_hit)
);

// File: tb/cache_wb_ctrl_bench.sv
module cache_wb_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 12;
   localparam int WORD_W     = 32;
   localparam int LINE_WORDS = 4;
   localparam int SETS       = 4;
   localparam int WAYS       = 2;
   localparam int MEM_WORDS  = 1 << (ADDR_W - 2);
   localparam int WATCHDOG   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0;
   logic              cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [WORD_W-1:0] cpu_wdata = '0;
   logic [3:0]        cpu_be = '0;
   logic              cpu_ready;
   logic [WORD_W-1:0] cpu_rdata;
   logic              mem_req;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_wdata;
   logic              mem_ready;
   logic [WORD_W-1:0] mem_rdata;

   logic [WORD_W-1:0] mem_img [MEM_WORDS];
   logic [WORD_W-1:0] ref_img [MEM_WORDS];
   int   mtag [SETS][WAYS];
   bit   mvld [SETS][WAYS];
   bit   mdrt [SETS][WAYS];
   int   mrr  [SETS];
   int   checks = 0;
   int   errors = 0;
   int   wb_total = 0;
   int   fill_pos = 0;
   int   cyc = 0;
   logic [31:0] rng = 32'h1F2E3D4C;

   always #(CLK_PERIOD/2) clk = ~clk;

   cache_wb_ctrl #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
      .SETS(SETS), .WAYS(WAYS)
   ) u_cache_wb_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   assign mem_ready = mem_req;
   assign mem_rdata = mem_img[mem_addr[ADDR_W-1:2]];

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         mem_img[mem_addr[ADDR_W-1:2]] <= mem_wdata;
         wb_total <= wb_total + 1;
      end
      if (mem_req && !mem_we) begin
         // R2: refill words come in ascending order
         checks++;
         if (int'(mem_addr[3:2]) != fill_pos) begin
            errors++;
            $display("FAIL R2 refill word order act=%0d exp=%0d", mem_addr[3:2], fill_pos);
         end
         fill_pos <= (fill_pos + 1) % LINE_WORDS;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < SETS; s++) begin
         mrr[s] = 0;
         for (int w = 0; w < WAYS; w++) begin
            mvld[s][w] = 1'b0;
            mdrt[s][w] = 1'b0;
            mtag[s][w] = 0;
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cpu_req = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      for (int i = 0; i < MEM_WORDS; i++) ref_img[i] = mem_img[i];
      @(negedge clk);
      // R1
      check(cpu_ready == 1'b0, "R1", "ready after reset", 32'(cpu_ready), 32'd0);
      check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
   endtask

   task automatic access(input bit we, input logic [ADDR_W-1:0] addr,
                         input logic [31:0] wd, input logic [3:0] be);
      int idx = int'(addr[5:4]);
      int tag = int'(addr[11:6]);
      int hw = -1;
      int vict = -1;
      int exp_lat, exp_wb, lat, wb0, old_tag;
      bit dirty_ev = 1'b0;
      string lat_rq;
      for (int w = 0; w < WAYS; w++)
         if (mvld[idx][w] && mtag[idx][w] == tag) hw = w;
      if (hw >= 0) begin
         exp_lat = 2; exp_wb = 0; lat_rq = "R3";
         if (we) mdrt[idx][hw] = 1'b1;
      end else begin
         for (int w = 0; w < WAYS; w++)
            if (!mvld[idx][w] && vict < 0) vict = w;
         if (vict < 0) begin
            vict = mrr[idx];
            mrr[idx] = (mrr[idx] + 1) % WAYS;
         end
         dirty_ev = mvld[idx][vict] && mdrt[idx][vict];
         old_tag  = mtag[idx][vict];
         exp_wb   = dirty_ev ? LINE_WORDS : 0;
         exp_lat  = 3 + LINE_WORDS + exp_wb;
         lat_rq   = dirty_ev ? "R7" : "R11";
         mtag[idx][vict] = tag;
         mvld[idx][vict] = 1'b1;
         mdrt[idx][vict] = we;
      end
      @(negedge clk);
      wb0 = wb_total;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
      lat = 0;
      do begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end while (!cpu_ready && lat < 60);
      check(lat == exp_lat, lat_rq, "access latency", 32'(lat), 32'(exp_lat));
      check((wb_total - wb0) == exp_wb, (hw >= 0 && we) ? "R6" : lat_rq,
            "write-back word count", 32'(wb_total - wb0), 32'(exp_wb));
      if (!we)
         check(cpu_rdata === ref_img[addr[11:2]], "R2", "read data",
               cpu_rdata, ref_img[addr[11:2]]);
      if (dirty_ev) begin
         for (int k = 0; k < LINE_WORDS; k++) begin
            int a = (old_tag << 4) | (idx << 2) | k;
            check(mem_img[a] === ref_img[a], "R7", "evicted word in memory",
                  mem_img[a], ref_img[a]);
         end
      end
      if (we) begin
         for (int b = 0; b < 4; b++)
            if (be[b]) ref_img[addr[11:2]][b*8 +: 8] = wd[b*8 +: 8];
      end
      cpu_req = 1'b0;
      @(negedge clk);
      check(cpu_ready == 1'b0, "R10", "ready lasts one cycle", 32'(cpu_ready), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < MEM_WORDS; i++) mem_img[i] = (i * 32'h9E3779B9) ^ 32'h1234_0000;
      do_reset();

      // R1 R5 R11 R2: read sweep over all words of tag 0, every set
      for (int a = 0; a < 64; a += 4) access(1'b0, ADDR_W'(a), '0, 4'h0);
      // R4 R5: tag 1 fills the second way of each set
      for (int a = 64; a < 128; a += 4) access(1'b0, ADDR_W'(a), '0, 4'h0);
      // R4: both tags still resident
      for (int a = 0; a < 128; a += 16) access(1'b0, ADDR_W'(a + 8), '0, 4'h0);

      // R9 R6: every byte-strobe pattern on one resident word
      for (int b = 0; b < 16; b++) begin
         access(1'b1, 12'h008, 32'hF0E1D2C3 ^ (b * 32'h01010101), 4'(b));
         access(1'b0, 12'h008, '0, 4'h0);
      end

      // R5 R7: set 0 full, pointer at way 0 -> dirty tag 0 evicted
      access(1'b0, 12'h080, '0, 4'h0);
      // R5 R11: pointer at way 1 -> clean tag 1 evicted
      access(1'b0, 12'h0C4, '0, 4'h0);

      // R8: write miss allocates, then merges
      access(1'b1, 12'h158, 32'hCAFE_0042, 4'b0101);
      access(1'b0, 12'h158, '0, 4'h0);
      access(1'b0, 12'h154, '0, 4'h0);

      // R1: reset drops dirty lines and empties the cache
      access(1'b1, 12'h020, 32'h5555_AAAA, 4'hF);
      do_reset();
      access(1'b0, 12'h020, '0, 4'h0);

      // mixed sweep over a small tag range, all requirements
      for (int n = 0; n < 600; n++) begin
         logic [ADDR_W-1:0] a;
         rng = next_rng(rng);
         a = {4'b0, rng[1:0], rng[5:2], 2'b00};
         access(rng[8], a, next_rng(rng ^ 32'h600D), rng[12:9]);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule